// File: doc/BRIEF.md
# Peer Announcement Message Decoder

This block sits behind the byte link from a control server. Bytes arrive one at a time on a valid/ready stream, in fragments of any length with idle gaps between them. The block rebuilds them into 64-bit signed messages, least significant byte first. A sideband flag tells whether an out-of-band handle travels with a message, and it is sampled together with the eighth byte of that message.

A handshake comes first. The first complete message must carry the expected protocol version, and no handle may come with it. If this check fails, the block stops taking bytes for good. Once the link is up, each message is a position, and its meaning depends on three things: its value, whether a handle came with it, and whether the block already knows its own ID. A position message can do one of four things:

- assign the block its own ID;
- record that a peer has left;
- announce the shared-memory region, which may happen only once;
- register the next event vector of a peer.

The peer table starts with room for a set number of peers and grows to hold the highest position seen, up to a hard limit. Vector counts are kept for the lowest positions and are reported on a flat output bus. When a vector is registered for the block's own ID, the block raises a one-cycle setup event that carries the vector's index.

Top module: `peer_msg_decoder`

## Requirements
- R1: After reset the own ID is -1, the link is neither up nor dead, shared memory is not mapped, peer capacity is 16, every vector count is 0, no pulse is active and `in_ready` is 1.
- R2: A message is the 8 accepted bytes taken least significant byte first. Idle gaps of any length may occur between bytes. The handle flag counts only on the eighth byte. Results appear after the second rising edge that follows the eighth byte.
- R3: The first message must equal `PROTO_VER` (default 0) with the handle flag at 0. If it does not, `err_valid` pulses with code 1, `link_dead` sets and stays set, and `in_ready` drops to 0. If it does, `link_up` sets.
- R4: Once the link is up, a position value below -1 changes nothing and raises no pulse, whatever the handle flag.
- R5: A non-negative position below 65535 with no handle, received while the own ID is -1, becomes the own ID. After that the own ID does not change until reset.
- R6: A non-negative position with no handle, received once the own ID is known, clears that peer's vector count. The value -1 with no handle is ignored.
- R7: The value -1 with a handle sets `shm_mapped`. Any later one pulses `err_valid` with code 2 and leaves `shm_mapped` set.
- R8: A non-negative position with a handle increments that peer's vector count. If the count already equals `MAX_VEC` (default 4), `err_valid` pulses with code 3 and the count stays as it is.
- R9: A position p in the range 0 to 65534 with p ≥ capacity sets the capacity to p+1. This happens before any rejection is decided. A position of 65535 or above pulses code 4 and has no other effect. The capacity never shrinks.
- R10: A vector that is accepted for the own ID pulses `setup_valid` for one cycle, with `setup_vec` set to the vector's index (the count before the increment). An error and a setup event never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte valid |
| in_data | input | 8 | Byte from server |
| in_handle | input | 1 | Handle-present flag, counted on the last byte |
| in_ready | output | 1 | Byte accepted when high |
| link_up | output | 1 | Version check passed |
| link_dead | output | 1 | Terminal handshake failure |
| shm_mapped | output | 1 | Shared memory announced |
| own_id | output | 17 | Own ID, signed, -1 when unknown |
| peer_cap | output | 16 | Current peer table capacity |
| vec_counts | output | 48 | 3-bit vector count per tracked peer, peer i at bits [3i+2:3i] |
| err_valid | output | 1 | One-cycle error pulse |
| err_code | output | 3 | 1 version, 2 duplicate memory, 3 vectors full, 4 position out of range |
| setup_valid | output | 1 | One-cycle interrupt-setup event |
| setup_vec | output | 3 | Vector index for the setup event |

## Verification
Each message passes through two registers. The assembler latches the full message on the edge that accepts its eighth byte, and the decoder updates its state and pulses on the next edge. The bench drives inputs on falling edges. After the eighth byte it waits exactly one more rising edge and samples on the falling edge that follows, which is the only cycle in which a one-cycle pulse is visible. It samples once more a cycle later to confirm the pulse has cleared. A model in the bench tracks vector counts and capacity arithmetically through a sweep of every tracked peer up to one vector past the limit.

// File: rtl/pmd_pkg.sv
package pmd_pkg;

    typedef struct packed {
        logic signed [63:0] value;
        logic               handle;
    } pmd_msg_t;

    typedef enum logic [2:0] {
        ACT_IGNORE,
        ACT_SET_OWN,
        ACT_DEPART,
        ACT_SHM,
        ACT_ADD_VEC,
        ACT_REJECT
    } pmd_act_e;

    typedef enum logic [2:0] {
        ERR_NONE      = 3'd0,
        ERR_VERSION   = 3'd1,
        ERR_SHM_DUP   = 3'd2,
        ERR_VEC_FULL  = 3'd3,
        ERR_RANGE     = 3'd4
    } pmd_err_e;

    typedef enum logic [1:0] {
        ST_WAIT_VER,
        ST_LINKED,
        ST_DEAD
    } pmd_state_e;

    function automatic int unsigned pmd_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pmd_assembler.sv
module pmd_assembler
    import pmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  logic [7:0] data,
    input  logic       handle,
    output logic       msg_valid,
    output pmd_msg_t   msg
);
    logic [2:0]  byte_cnt;
    logic [55:0] partial;

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_cnt  <= '0;
            partial   <= '0;
            msg_valid <= 1'b0;
            msg       <= '0;
        end else begin
            msg_valid <= 1'b0;
            if (accept) begin
                byte_cnt <= byte_cnt + 3'd1;
                if (byte_cnt == 3'd7) begin
                    msg_valid    <= 1'b1;
                    msg.value    <= $signed({data, partial});
                    msg.handle   <= handle;
                end else begin
                    partial <= {data, partial[55:8]};
                end
            end
        end
    end
endmodule

// File: rtl/pmd_classifier.sv
module pmd_classifier
    import pmd_pkg::*;
#(
    parameter int MAX_PEERS = 65535,
    parameter int MAX_VEC   = 4,
    localparam int CAP_W    = $clog2(MAX_PEERS + 1),
    localparam int CW       = $clog2(MAX_VEC + 1)
) (
    input  pmd_msg_t         msg,
    input  logic             own_known,
    input  logic             shm_done,
    input  logic [CW-1:0]    cur_count,
    output pmd_act_e         act,
    output pmd_err_e         err,
    output logic             pos_ok,
    output logic [CAP_W-1:0] pos
);
    logic is_neg1, below, too_big;

    always_comb begin
        is_neg1 = (msg.value == -64'sd1);
        below   = (msg.value < -64'sd1);
        too_big = (msg.value >= $signed(64'(MAX_PEERS)));
        pos_ok  = !below && !is_neg1 && !too_big;
        pos     = msg.value[CAP_W-1:0];
        act     = ACT_IGNORE;
        err     = ERR_NONE;
        if (below) begin
            act = ACT_IGNORE;
        end else if (too_big) begin
            act = ACT_REJECT;
            err = ERR_RANGE;
        end else if (!msg.handle) begin
            if (is_neg1)         act = ACT_IGNORE;
            else if (!own_known) act = ACT_SET_OWN;
            else                 act = ACT_DEPART;
        end else if (is_neg1) begin
            if (shm_done) begin
                act = ACT_REJECT;
                err = ERR_SHM_DUP;
            end else begin
                act = ACT_SHM;
            end
        end else if (cur_count >= CW'(MAX_VEC)) begin
            act = ACT_REJECT;
            err = ERR_VEC_FULL;
        end else begin
            act = ACT_ADD_VEC;
        end
    end
endmodule

// File: rtl/pmd_vector_table.sv
module pmd_vector_table #(
    parameter int TRACK_PEERS = 16,
    parameter int MAX_VEC     = 4,
    parameter int CAP_W       = 16,
    localparam int CW         = $clog2(MAX_VEC + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [CAP_W-1:0]          idx,
    input  logic                      inc,
    input  logic                      clr,
    output logic [CW-1:0]             rd_count,
    output logic [TRACK_PEERS*CW-1:0] counts
);
    logic tracked;
    assign tracked = (idx < CAP_W'(TRACK_PEERS));

    for (genvar i = 0; i < TRACK_PEERS; i++) begin : g_slot
        logic hit;
        assign hit = tracked && (idx == CAP_W'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                counts[i*CW +: CW] <= '0;
            end else if (hit && clr) begin
                counts[i*CW +: CW] <= '0;
            end else if (hit && inc) begin
                counts[i*CW +: CW] <= counts[i*CW +: CW] + CW'(1);
            end
        end
    end

    always_comb begin
        rd_count = '0;
        for (int i = 0; i < TRACK_PEERS; i++) begin
            if (tracked && idx == CAP_W'(i)) rd_count = counts[i*CW +: CW];
        end
    end
endmodule

// File: rtl/peer_msg_decoder.sv
module peer_msg_decoder
    import pmd_pkg::*;
#(
    parameter logic signed [63:0] PROTO_VER = 64'sd0,
    parameter int MAX_PEERS   = 65535,
    parameter int INIT_PEERS  = 16,
    parameter int TRACK_PEERS = 16,
    parameter int MAX_VEC     = 4,
    localparam int CAP_W      = $clog2(MAX_PEERS + 1),
    localparam int ID_W       = CAP_W + 1,
    localparam int CW         = $clog2(MAX_VEC + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [7:0]                in_data,
    input  logic                      in_handle,
    output logic                      in_ready,
    output logic                      link_up,
    output logic                      link_dead,
    output logic                      shm_mapped,
    output logic signed [ID_W-1:0]    own_id,
    output logic [CAP_W-1:0]          peer_cap,
    output logic [TRACK_PEERS*CW-1:0] vec_counts,
    output logic                      err_valid,
    output logic [2:0]                err_code,
    output logic                      setup_valid,
    output logic [CW-1:0]             setup_vec
);
    pmd_state_e       state;
    logic             msg_valid;
    pmd_msg_t         msg;
    pmd_act_e         act;
    pmd_err_e         cls_err;
    logic             pos_ok;
    logic [CAP_W-1:0] pos;
    logic [CW-1:0]    cur_count;
    logic             own_known, own_match, linked_msg;

    assign in_ready   = (state != ST_DEAD);
    assign link_up    = (state == ST_LINKED);
    assign link_dead  = (state == ST_DEAD);
    assign own_known  = (own_id != -ID_W'(1));
    assign own_match  = own_known && (own_id == $signed({1'b0, pos}));
    assign linked_msg = msg_valid && (state == ST_LINKED);

    pmd_assembler u_asm (
        .clk       (clk),
        .rst       (rst),
        .accept    (in_valid && in_ready),
        .data      (in_data),
        .handle    (in_handle),
        .msg_valid (msg_valid),
        .msg       (msg)
    );

    pmd_classifier #(.MAX_PEERS(MAX_PEERS), .MAX_VEC(MAX_VEC)) u_cls (
        .msg       (msg),
        .own_known (own_known),
        .shm_done  (shm_mapped),
        .cur_count (cur_count),
        .act       (act),
        .err       (cls_err),
        .pos_ok    (pos_ok),
        .pos       (pos)
    );

    pmd_vector_table #(
        .TRACK_PEERS(TRACK_PEERS), .MAX_VEC(MAX_VEC), .CAP_W(CAP_W)
    ) u_tab (
        .clk      (clk),
        .rst      (rst),
        .idx      (pos),
        .inc      (linked_msg && act == ACT_ADD_VEC),
        .clr      (linked_msg && act == ACT_DEPART),
        .rd_count (cur_count),
        .counts   (vec_counts)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_WAIT_VER;
            own_id      <= -ID_W'(1);
            shm_mapped  <= 1'b0;
            peer_cap    <= CAP_W'(INIT_PEERS);
            err_valid   <= 1'b0;
            err_code    <= ERR_NONE;
            setup_valid <= 1'b0;
            setup_vec   <= '0;
        end else begin
            err_valid   <= 1'b0;
            setup_valid <= 1'b0;
            if (msg_valid && state == ST_WAIT_VER) begin
                if (msg.value == PROTO_VER && !msg.handle) begin
                    state <= ST_LINKED;
                end else begin
                    state     <= ST_DEAD;
                    err_valid <= 1'b1;
                    err_code  <= ERR_VERSION;
                end
            end else if (linked_msg) begin
                if (pos_ok && pos >= peer_cap) peer_cap <= pos + CAP_W'(1);
                case (act)
                    ACT_SET_OWN: own_id     <= $signed({1'b0, pos});
                    ACT_SHM:     shm_mapped <= 1'b1;
                    ACT_ADD_VEC: begin
                        if (own_match) begin
                            setup_valid <= 1'b1;
                            setup_vec   <= cur_count;
                        end
                    end
                    ACT_REJECT: begin
                        err_valid <= 1'b1;
                        err_code  <= cls_err;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/pmd_checker.sv
module pmd_checker #(
    parameter int CAP_W = 16,
    parameter int ID_W  = 17
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_ready,
    input logic                   link_up,
    input logic                   link_dead,
    input logic                   shm_mapped,
    input logic signed [ID_W-1:0] own_id,
    input logic [CAP_W-1:0]       peer_cap,
    input logic                   err_valid,
    input logic                   setup_valid
);
    assert_dead_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        link_dead |=> link_dead);

    assert_dead_not_ready_R3: assert property (@(posedge clk) disable iff (rst)
        link_dead |-> (!in_ready && !link_up));

    assert_shm_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        shm_mapped |=> shm_mapped);

    assert_own_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (own_id >= 0) |=> $stable(own_id));

    assert_cap_monotonic_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (peer_cap >= $past(peer_cap)));

    assert_pulse_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(err_valid && setup_valid));
endmodule

bind peer_msg_decoder pmd_checker #(.CAP_W(CAP_W), .ID_W(ID_W)) u_pmd_chk (
    .clk         (clk),
    .rst         (rst),
    .in_ready    (in_ready),
    .link_up     (link_up),
    .link_dead   (link_dead),
    .shm_mapped  (shm_mapped),
    .own_id      (own_id),
    .peer_cap    (peer_cap),
    .err_valid   (err_valid),
    .setup_valid (setup_valid)
);

// File: tb/peer_msg_decoder_tb.sv
module peer_msg_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TRACK = 16;
    localparam int MAXV  = 4;
    localparam int CW    = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic in_handle = 1'b0;
    logic in_ready, link_up, link_dead, shm_mapped, err_valid, setup_valid;
    logic signed [16:0] own_id;
    logic [15:0] peer_cap;
    logic [TRACK*CW-1:0] vec_counts;
    logic [2:0] err_code;
    logic [CW-1:0] setup_vec;

    int checks = 0;
    int errors = 0;
    int model_cnt [TRACK];
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    peer_msg_decoder u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_handle(in_handle), .in_ready(in_ready), .link_up(link_up),
        .link_dead(link_dead), .shm_mapped(shm_mapped), .own_id(own_id),
        .peer_cap(peer_cap), .vec_counts(vec_counts), .err_valid(err_valid),
        .err_code(err_code), .setup_valid(setup_valid), .setup_vec(setup_vec)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_msg(input longint v, input bit h, input int gap);
        for (int b = 0; b < 8; b++) begin
            in_valid  = 1'b1;
            in_data   = 8'(v >> (8 * b));
            in_handle = (b == 7) ? h : !h;
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            if (b < 7) repeat (gap) @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < TRACK; i++) model_cnt[i] = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1 own_id", own_id, -1);
        check("R1 link_up", link_up, 0);
        check("R1 link_dead", link_dead, 0);
        check("R1 shm", shm_mapped, 0);
        check("R1 cap", peer_cap, 16);
        check("R1 counts", vec_counts, 0);
        check("R1 ready", in_ready, 1);
        check("R1 pulses", {err_valid, setup_valid}, 0);

        // R3 wrong version value
        send_msg(7, 1'b0, 2);
        check("R3 err pulse", err_valid, 1);
        check("R3 err code", err_code, 1);
        check("R3 dead", link_dead, 1);
        check("R3 ready low", in_ready, 0);
        @(negedge clk);
        check("R3 pulse one cycle", err_valid, 0);
        check("R3 still dead", link_dead, 1);

        // R3 right version with handle
        do_reset();
        send_msg(0, 1'b1, 0);
        check("R3 handle rejects", link_dead, 1);
        check("R3 handle code", err_code, 1);

        // R2 R3 fragmented valid version
        do_reset();
        send_msg(0, 1'b0, 5);
        check("R2 R3 link up", link_up, 1);
        check("R3 no err", err_valid, 0);

        // R4 below -1
        send_msg(-5, 1'b1, 1);
        check("R4 no err", err_valid, 0);
        check("R4 own", own_id, -1);
        check("R4 shm", shm_mapped, 0);
        send_msg(-64'sd9000000000, 1'b0, 0);
        check("R4 own still", own_id, -1);
        check("R4 cap", peer_cap, 16);

        // R5 own id, R2 multibyte value
        send_msg(3, 1'b0, 3);
        check("R5 own", own_id, 3);
        send_msg(9, 1'b0, 0);
        check("R5 own kept", own_id, 3);

        // R8 R10 sweep
        for (int p = 0; p < TRACK; p++) begin
            for (int v = 0; v <= MAXV; v++) begin
                send_msg(p, 1'b1, (p + v) % 3);
                if (v < MAXV) begin
                    model_cnt[p]++;
                    check("R8 no err", err_valid, 0);
                    check("R10 setup", setup_valid, (p == 3) ? 1 : 0);
                    if (p == 3) check("R10 vec", setup_vec, v);
                end else begin
                    check("R8 full err", err_valid, 1);
                    check("R8 full code", err_code, 3);
                    check("R10 no setup", setup_valid, 0);
                end
                check("R8 count", vec_counts[p*CW +: CW], model_cnt[p]);
            end
        end

        // R6 depart
        send_msg(5, 1'b0, 0);
        model_cnt[5] = 0;
        check("R6 cleared", vec_counts[5*CW +: CW], 0);
        check("R6 others", vec_counts[4*CW +: CW], MAXV);
        send_msg(5, 1'b1, 0);
        check("R6 re-add", vec_counts[5*CW +: CW], 1);
        send_msg(-1, 1'b0, 0);
        check("R6 -1 ignored err", err_valid, 0);
        check("R6 -1 ignored counts", vec_counts[0 +: CW], MAXV);

        // R9 capacity
        send_msg(40, 1'b1, 0);
        check("R9 grow", peer_cap, 41);
        check("R9 no err", err_valid, 0);
        send_msg(20, 1'b1, 0);
        check("R9 no shrink", peer_cap, 41);
        send_msg(65535, 1'b1, 0);
        check("R9 range err", err_valid, 1);
        check("R9 range code", err_code, 4);
        check("R9 range cap", peer_cap, 41);
        send_msg(65534, 1'b0, 0);
        check("R9 top grow", peer_cap, 65535);
        check("R9 top no err", err_valid, 0);

        // R7 shared memory
        send_msg(-1, 1'b1, 1);
        check("R7 mapped", shm_mapped, 1);
        check("R7 first no err", err_valid, 0);
        send_msg(-1, 1'b1, 0);
        check("R7 dup err", err_valid, 1);
        check("R7 dup code", err_code, 2);
        check("R7 still mapped", shm_mapped, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule